// File: doc/BRIEF.md
# Runahead Checkpoint and Poison Controller

This block sits beside a simple in-order pipeline. When a load misses in the data cache, the pipeline does not stall. It keeps executing in a speculative mode whose only purpose is to discover and launch further memory requests early. The block owns the register file. Every register carries a poison flag. A register is poisoned when its value could not be computed because it depends on the outstanding miss. On entering the speculative mode the block copies every register into a backup bank. On leaving it, the block copies the backup back, clears every poison flag and asks fetch to restart at the load that missed.

While the speculative mode is active, the block gates what the pipeline may do. A memory request whose base register is poisoned is refused. So is a request that targets the same cache line as the pending miss, and a request made when the in-flight limit has been reached. A granted request acts as a prefetch. A branch that reads a poisoned operand holds the pipeline. The data cache write enable is withdrawn, so neither stores nor returning fill data change the cache until normal mode resumes.

A parameter selects the exit policy. The block can leave as soon as the missing load's line returns, or it can wait until that line and every prefetch it granted have all come back.

Top module: `runahead_ctl`

## Requirements
- R1: A miss (`miss_valid`) in normal mode sets `runahead` at the next clock edge. It also saves the register contents as they stood before that cycle's writes, and records `miss_pc` and `miss_line`.
- R2: A register write with `wr_inv` set, made in speculative mode or in the entry cycle, leaves the destination reading `rd_inv`=1.
- R3: A write in speculative mode whose source index `wr_src_a` or `wr_src_b` names a poisoned register marks its destination poisoned. A write whose sources are all clean leaves its destination clean.
- R4: In speculative mode, `req_grant` is 0 when the register named by `req_base` is poisoned.
- R5: In speculative mode, `req_grant` is 0 when `req_line` equals the pending miss line, or when MAXFLY requests are in flight. The offending miss counts as one of these requests.
- R6: In speculative mode, `br_stall` is 1 when `br_valid` is set and either branch source is poisoned. Otherwise it is 0.
- R7: `dc_write_ok` is 0 exactly while `runahead` is 1.
- R8: With EXIT_ALL=0, a response whose line equals the pending line clears `runahead` at the next edge. In that same cycle the backup is restored, all poison flags are cleared, and `redirect_valid` pulses for one cycle with `redirect_pc` equal to the recorded miss PC.
- R9: With EXIT_ALL=1, the exit described in R8 waits until the pending line has returned and the in-flight count has dropped to zero.
- R10: A miss that arrives while already in speculative mode takes no new checkpoint and does not change the restart PC.
- R11: Register 0 always reads data 0 with `rd_inv`=0, whatever is written to it.
- R12: In normal mode, writes store data with `rd_inv`=0 even when `wr_inv` is set, and `req_grant` follows `req_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | A load missed in the data cache this cycle |
| miss_pc | input | PCW | PC of the missing load |
| miss_line | input | LINEW | Cache line index of the missing load |
| wr_en | input | NWP | Write enable for each write port |
| wr_idx | input | NWP x AW | Destination register of each write port |
| wr_data | input | NWP x XLEN | Write data of each write port |
| wr_src_a | input | NWP x AW | First source register of the writing instruction |
| wr_src_b | input | NWP x AW | Second source register of the writing instruction |
| wr_inv | input | NWP | Result is poisoned by itself (for example, a missing load) |
| rd_idx | input | NRP x AW | Read address of each read port |
| rd_data | output | NRP x XLEN | Read data |
| rd_inv | output | NRP | Poison flag of the register that was read |
| req_valid | input | 1 | Pipeline asks to send a memory request |
| req_base | input | AW | Base address register of the request |
| req_line | input | LINEW | Cache line index of the request |
| req_grant | output | 1 | Request may go to memory |
| br_valid | input | 1 | A branch is resolving this cycle |
| br_src_a | input | AW | First branch predicate source |
| br_src_b | input | AW | Second branch predicate source |
| br_stall | output | 1 | Hold the branch |
| resp_valid | input | 1 | A memory response returns this cycle |
| resp_line | input | LINEW | Line index of the response |
| dc_write_ok | output | 1 | Data cache may be written |
| runahead | output | 1 | Speculative mode is active |
| redirect_valid | output | 1 | One-cycle pulse: restart fetch |
| redirect_pc | output | PCW | Restart PC (the missing load) |

## Verification
The assertions check, on every cycle, the rules that limit speculative mode. A granted request never uses a poisoned base or the pending line, the cache is never writable in speculative mode, and no poison flag survives in normal mode. They also check that a checkpoint is taken only on entry, that a restore brings back the saved bank, and that every exit produces the redirect pulse. The bench scenarios are needed to show the value-level behaviour. This covers poison flowing through a chain of dependent writes, an older value coming back after a restore, the restart PC staying at the first miss despite a second miss, and the two exit policies diverging once prefetches are still outstanding.

// File: rtl/ra_pkg.sv
package ra_pkg;
    // Exit policy selector values
    localparam bit EXIT_ON_MISS = 1'b0;
    localparam bit EXIT_ON_ALL  = 1'b1;

    function automatic int unsigned cnt_bits(input int unsigned maxv);
        return $clog2(maxv + 1);
    endfunction
endpackage

// File: rtl/ra_regfile.sv
module ra_regfile #(
    parameter int NREGS = 8,
    parameter int XLEN  = 16,
    parameter int NWP   = 2,
    parameter int NRP   = 2,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      save,
    input  logic                      restore,
    input  logic                      ra_act,
    input  logic [NWP-1:0]            wr_en,
    input  logic [NWP-1:0][AW-1:0]    wr_idx,
    input  logic [NWP-1:0][XLEN-1:0]  wr_data,
    input  logic [NWP-1:0][AW-1:0]    wr_src_a,
    input  logic [NWP-1:0][AW-1:0]    wr_src_b,
    input  logic [NWP-1:0]            wr_inv,
    input  logic [NRP-1:0][AW-1:0]    rd_idx,
    output logic [NRP-1:0][XLEN-1:0]  rd_data,
    output logic [NRP-1:0]            rd_inv,
    output logic [NREGS-1:0]          inv_vec
);
    typedef struct packed {
        logic [NREGS-1:0][XLEN-1:0] live;
        logic [NREGS-1:0][XLEN-1:0] bak;
        logic [NREGS-1:0]           inv;
    } rf_t;

    rf_t rf_d, rf_q;

    always_comb begin
        rf_d = rf_q;
        if (restore) begin
            rf_d.live = rf_q.bak;
            rf_d.inv  = '0;
        end else begin
            if (save) rf_d.bak = rf_q.live;
            for (int p = 0; p < NWP; p++) begin
                if (wr_en[p] && (wr_idx[p] != '0)) begin
                    rf_d.live[wr_idx[p]] = wr_data[p];
                    rf_d.inv[wr_idx[p]]  = ra_act &&
                        (wr_inv[p] || rf_q.inv[wr_src_a[p]] || rf_q.inv[wr_src_b[p]]);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rf_q <= '0;
        else        rf_q <= rf_d;
    end

    for (genvar r = 0; r < NRP; r++) begin : g_rd
        assign rd_data[r] = (rd_idx[r] == '0) ? '0   : rf_q.live[rd_idx[r]];
        assign rd_inv[r]  = (rd_idx[r] == '0) ? 1'b0 : rf_q.inv[rd_idx[r]];
    end

    assign inv_vec = rf_q.inv;

    // R1
    save_copies_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (save && !restore) |=> (rf_q.bak == $past(rf_q.live)));
    // R8
    restore_brings_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restore |=> (rf_q.live == $past(rf_q.bak)) && (rf_q.inv == '0));
    // R11
    zero_never_poisoned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rf_q.inv[0]);
endmodule

// File: rtl/ra_mode.sv
module ra_mode #(
    parameter int PCW      = 16,
    parameter int LINEW    = 6,
    parameter int MAXFLY   = 4,
    parameter bit EXIT_ALL = 1'b0,
    localparam int CW      = ra_pkg::cnt_bits(MAXFLY)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             miss_valid,
    input  logic [PCW-1:0]   miss_pc,
    input  logic [LINEW-1:0] miss_line,
    input  logic             req_fire,
    input  logic             resp_valid,
    input  logic [LINEW-1:0] resp_line,
    output logic             ra,
    output logic             enter,
    output logic             leave,
    output logic [LINEW-1:0] pend_line,
    output logic             fly_full,
    output logic             redirect_valid,
    output logic [PCW-1:0]   redirect_pc
);
    typedef struct packed {
        logic             ra;
        logic [PCW-1:0]   pc;
        logic [LINEW-1:0] line;
        logic [CW-1:0]    cnt;
        logic             done;
        logic             redir;
    } md_t;

    md_t md_d, md_q;

    logic          hit;
    logic [CW-1:0] cnt_nx;
    logic          exit_cond;

    assign hit    = resp_valid && (resp_line == md_q.line) && !md_q.done;
    assign cnt_nx = md_q.cnt + CW'(req_fire) - CW'(resp_valid && (md_q.cnt != '0));

    if (EXIT_ALL == ra_pkg::EXIT_ON_ALL) begin : g_exit_all
        assign exit_cond = (md_q.done || hit) && (cnt_nx == '0);
    end else begin : g_exit_miss
        assign exit_cond = hit;
    end

    always_comb begin
        md_d       = md_q;
        md_d.redir = 1'b0;
        enter      = 1'b0;
        leave      = 1'b0;
        if (!md_q.ra) begin
            if (miss_valid) begin
                enter     = 1'b1;
                md_d.ra   = 1'b1;
                md_d.pc   = miss_pc;
                md_d.line = miss_line;
                md_d.cnt  = CW'(1);
                md_d.done = 1'b0;
            end
        end else begin
            md_d.cnt  = cnt_nx;
            md_d.done = md_q.done || hit;
            if (exit_cond) begin
                leave      = 1'b1;
                md_d.ra    = 1'b0;
                md_d.redir = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) md_q <= '0;
        else        md_q <= md_d;
    end

    assign ra             = md_q.ra;
    assign pend_line      = md_q.line;
    assign fly_full       = (md_q.cnt >= CW'(MAXFLY));
    assign redirect_valid = md_q.redir;
    assign redirect_pc    = md_q.pc;

    // R1
    enter_sets_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ra && miss_valid) |=> ra);
    // R10
    second_miss_keeps_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ra && miss_valid) |=> $stable(redirect_pc));
    // R8
    leave_pulses_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        leave |=> (!ra && redirect_valid));
    // R5
    fly_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        md_q.cnt <= CW'(MAXFLY));
endmodule

// File: rtl/ra_gate.sv
module ra_gate #(
    parameter int NREGS = 8,
    parameter int LINEW = 6,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic             ra,
    input  logic [NREGS-1:0] inv_vec,
    input  logic [LINEW-1:0] pend_line,
    input  logic             fly_full,
    input  logic             req_valid,
    input  logic [AW-1:0]    req_base,
    input  logic [LINEW-1:0] req_line,
    input  logic             br_valid,
    input  logic [AW-1:0]    br_src_a,
    input  logic [AW-1:0]    br_src_b,
    output logic             req_grant,
    output logic             req_fire,
    output logic             br_stall,
    output logic             dc_write_ok
);
    logic spec_ok;

    always_comb begin
        spec_ok     = !inv_vec[req_base] && (req_line != pend_line) && !fly_full;
        req_grant   = req_valid && (!ra || spec_ok);
        req_fire    = req_grant && ra;
        br_stall    = ra && br_valid && (inv_vec[br_src_a] || inv_vec[br_src_b]);
        dc_write_ok = !ra;
    end
endmodule

// File: rtl/runahead_ctl.sv
module runahead_ctl #(
    parameter int NREGS    = 8,
    parameter int XLEN     = 16,
    parameter int NWP      = 2,
    parameter int NRP      = 2,
    parameter int PCW      = 16,
    parameter int LINEW    = 6,
    parameter int MAXFLY   = 4,
    parameter bit EXIT_ALL = 1'b0,
    localparam int AW      = $clog2(NREGS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      miss_valid,
    input  logic [PCW-1:0]            miss_pc,
    input  logic [LINEW-1:0]          miss_line,
    input  logic [NWP-1:0]            wr_en,
    input  logic [NWP-1:0][AW-1:0]    wr_idx,
    input  logic [NWP-1:0][XLEN-1:0]  wr_data,
    input  logic [NWP-1:0][AW-1:0]    wr_src_a,
    input  logic [NWP-1:0][AW-1:0]    wr_src_b,
    input  logic [NWP-1:0]            wr_inv,
    input  logic [NRP-1:0][AW-1:0]    rd_idx,
    output logic [NRP-1:0][XLEN-1:0]  rd_data,
    output logic [NRP-1:0]            rd_inv,
    input  logic                      req_valid,
    input  logic [AW-1:0]             req_base,
    input  logic [LINEW-1:0]          req_line,
    output logic                      req_grant,
    input  logic                      br_valid,
    input  logic [AW-1:0]             br_src_a,
    input  logic [AW-1:0]             br_src_b,
    output logic                      br_stall,
    input  logic                      resp_valid,
    input  logic [LINEW-1:0]          resp_line,
    output logic                      dc_write_ok,
    output logic                      runahead,
    output logic                      redirect_valid,
    output logic [PCW-1:0]            redirect_pc
);
    logic             ra, enter, leave, fly_full, req_fire;
    logic [LINEW-1:0] pend_line;
    logic [NREGS-1:0] inv_vec;

    ra_mode #(.PCW(PCW), .LINEW(LINEW), .MAXFLY(MAXFLY), .EXIT_ALL(EXIT_ALL)) u_mode (
        .clk(clk), .rst_n(rst_n),
        .miss_valid(miss_valid), .miss_pc(miss_pc), .miss_line(miss_line),
        .req_fire(req_fire), .resp_valid(resp_valid), .resp_line(resp_line),
        .ra(ra), .enter(enter), .leave(leave), .pend_line(pend_line),
        .fly_full(fly_full), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
    );

    ra_regfile #(.NREGS(NREGS), .XLEN(XLEN), .NWP(NWP), .NRP(NRP)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .save(enter), .restore(leave), .ra_act(ra || enter),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .wr_src_a(wr_src_a), .wr_src_b(wr_src_b), .wr_inv(wr_inv),
        .rd_idx(rd_idx), .rd_data(rd_data), .rd_inv(rd_inv), .inv_vec(inv_vec)
    );

    ra_gate #(.NREGS(NREGS), .LINEW(LINEW)) u_gate (
        .ra(ra), .inv_vec(inv_vec), .pend_line(pend_line), .fly_full(fly_full),
        .req_valid(req_valid), .req_base(req_base), .req_line(req_line),
        .br_valid(br_valid), .br_src_a(br_src_a), .br_src_b(br_src_b),
        .req_grant(req_grant), .req_fire(req_fire), .br_stall(br_stall),
        .dc_write_ok(dc_write_ok)
    );

    assign runahead = ra;

    // R12
    clean_in_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ra |-> (inv_vec == '0));
    // R4
    grant_base_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ra && req_grant) |-> !inv_vec[req_base]);
    // R5
    grant_no_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ra && req_grant) |-> (req_line != pend_line));
    // R7
    cache_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ra |-> !dc_write_ok);
    // R6
    branch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ra && br_valid && (inv_vec[br_src_a] || inv_vec[br_src_b])) |-> br_stall);
endmodule

// File: tb/runahead_ctl_test.sv
module runahead_ctl_test;
    localparam int NREGS = 8, XLEN = 16, NWP = 2, NRP = 2, PCW = 16, LINEW = 6, MAXFLY = 4;
    localparam int AW = $clog2(NREGS);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic                     miss_valid;
    logic [PCW-1:0]           miss_pc;
    logic [LINEW-1:0]         miss_line;
    logic [NWP-1:0]           wr_en;
    logic [NWP-1:0][AW-1:0]   wr_idx;
    logic [NWP-1:0][XLEN-1:0] wr_data;
    logic [NWP-1:0][AW-1:0]   wr_src_a, wr_src_b;
    logic [NWP-1:0]           wr_inv;
    logic [NRP-1:0][AW-1:0]   rd_idx;
    logic [NRP-1:0][XLEN-1:0] rd_data, rd_data_b;
    logic [NRP-1:0]           rd_inv, rd_inv_b;
    logic                     req_valid;
    logic [AW-1:0]            req_base;
    logic [LINEW-1:0]         req_line;
    logic                     req_grant, req_grant_b;
    logic                     br_valid;
    logic [AW-1:0]            br_src_a, br_src_b;
    logic                     br_stall, br_stall_b;
    logic                     resp_valid;
    logic [LINEW-1:0]         resp_line;
    logic                     dc_write_ok, dc_write_ok_b;
    logic                     runahead, runahead_b;
    logic                     redirect_valid, redirect_valid_b;
    logic [PCW-1:0]           redirect_pc, redirect_pc_b;

    runahead_ctl #(.EXIT_ALL(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_pc(miss_pc), .miss_line(miss_line),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_src_a(wr_src_a), .wr_src_b(wr_src_b),
        .wr_inv(wr_inv), .rd_idx(rd_idx), .rd_data(rd_data), .rd_inv(rd_inv),
        .req_valid(req_valid), .req_base(req_base), .req_line(req_line), .req_grant(req_grant),
        .br_valid(br_valid), .br_src_a(br_src_a), .br_src_b(br_src_b), .br_stall(br_stall),
        .resp_valid(resp_valid), .resp_line(resp_line), .dc_write_ok(dc_write_ok),
        .runahead(runahead), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc));

    runahead_ctl #(.EXIT_ALL(1'b1)) uut_all (
        .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_pc(miss_pc), .miss_line(miss_line),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_src_a(wr_src_a), .wr_src_b(wr_src_b),
        .wr_inv(wr_inv), .rd_idx(rd_idx), .rd_data(rd_data_b), .rd_inv(rd_inv_b),
        .req_valid(req_valid), .req_base(req_base), .req_line(req_line), .req_grant(req_grant_b),
        .br_valid(br_valid), .br_src_a(br_src_a), .br_src_b(br_src_b), .br_stall(br_stall_b),
        .resp_valid(resp_valid), .resp_line(resp_line), .dc_write_ok(dc_write_ok_b),
        .runahead(runahead_b), .redirect_valid(redirect_valid_b), .redirect_pc(redirect_pc_b));

    int total = 0;
    int bad = 0;

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chkv(input string tag, input logic [31:0] act, input logic [31:0] exp);
        chk(act === exp, tag, act, exp);
    endtask

    task automatic idle();
        miss_valid = 0; miss_pc = '0; miss_line = '0;
        wr_en = '0; wr_idx = '0; wr_data = '0; wr_src_a = '0; wr_src_b = '0; wr_inv = '0;
        req_valid = 0; req_base = '0; req_line = '0;
        br_valid = 0; br_src_a = '0; br_src_b = '0;
        resp_valid = 0; resp_line = '0;
    endtask

    // advance one edge; inputs change at negedge, outputs read 1 ns after it
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle();
        #1;
    endtask

    task automatic wr(input int p, input int idx, input int data, input int sa, input int sb, input logic inv);
        wr_en[p] = 1'b1; wr_idx[p] = AW'(idx); wr_data[p] = XLEN'(data);
        wr_src_a[p] = AW'(sa); wr_src_b[p] = AW'(sb); wr_inv[p] = inv;
    endtask

    task automatic rd(input int idx);
        rd_idx[0] = AW'(idx);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle();
        rd_idx = '0;
        rst_n = 0;
        step(); step();
        rst_n = 1;
        #1;
    endtask

    task automatic t_reset();
        do_reset();
        chkv("R1 reset runahead", runahead, 0);
        chkv("R8 reset redirect", redirect_valid, 0);
        chkv("R7 reset dc_write_ok", dc_write_ok, 1);
        rd(3);
        chkv("R11 reset data", rd_data[0], 0);
    endtask

    task automatic t_normal();
        do_reset();
        wr(0, 1, 'h11, 2, 3, 1'b1);
        wr(1, 0, 'h99, 0, 0, 1'b1);
        step();
        rd(1);
        chkv("R12 normal data", rd_data[0], 'h11);
        chkv("R12 normal inv ignored", rd_inv[0], 0);
        rd(0);
        chkv("R11 r0 data", rd_data[0], 0);
        chkv("R11 r0 inv", rd_inv[0], 0);
        req_valid = 1; req_base = 1; req_line = 4; #1;
        chkv("R12 normal grant", req_grant, 1);
        req_valid = 0; #1;
        chkv("R12 normal no grant", req_grant, 0);
    endtask

    task automatic t_enter_exit();
        do_reset();
        wr(0, 1, 'hAA, 0, 0, 1'b0);
        wr(1, 2, 'hBB, 0, 0, 1'b0);
        step();
        miss_valid = 1; miss_pc = 'h40; miss_line = 5;
        wr(0, 3, 'h77, 0, 0, 1'b1);
        step();
        chkv("R1 enter", runahead, 1);
        rd(3);
        chkv("R2 load dest inv", rd_inv[0], 1);
        wr(0, 4, 'h12, 3, 0, 1'b0);
        wr(1, 1, 'h55, 0, 0, 1'b0);
        step();
        wr(0, 5, 'h07, 1, 2, 1'b0);
        wr(1, 0, 'h01, 3, 0, 1'b1);
        step();
        rd(4);
        chkv("R3 dependent inv", rd_inv[0], 1);
        rd(5);
        chkv("R3 clean sources", rd_inv[0], 0);
        rd(1);
        chkv("R3 runahead data", rd_data[0], 'h55);
        rd(0);
        chkv("R11 r0 in runahead", rd_inv[0], 0);
        req_valid = 1; req_base = 4; req_line = 7; #1;
        chkv("R4 inv base refused", req_grant, 0);
        req_base = 1; req_line = 5; #1;
        chkv("R5 collision refused", req_grant, 0);
        req_line = 7; #1;
        chkv("R4 clean base granted", req_grant, 1);
        chkv("R7 cache locked", dc_write_ok, 0);
        br_valid = 1; br_src_a = 2; br_src_b = 4; #1;
        chkv("R6 branch stall", br_stall, 1);
        br_src_b = 1; #1;
        chkv("R6 clean branch", br_stall, 0);
        step();
        miss_valid = 1; miss_pc = 'h80; miss_line = 9;
        step();
        resp_valid = 1; resp_line = 7;
        step();
        chkv("R8 other line stays", runahead, 1);
        chkv("R10 pc kept", redirect_pc, 'h40);
        resp_valid = 1; resp_line = 5;
        step();
        chkv("R8 exit", runahead, 0);
        chkv("R8 redirect", redirect_valid, 1);
        chkv("R10 redirect pc", redirect_pc, 'h40);
        chkv("R7 cache unlocked", dc_write_ok, 1);
        rd(1);
        chkv("R8 restored data", rd_data[0], 'hAA);
        rd(3);
        chkv("R8 restored r3", rd_data[0], 0);
        chkv("R8 inv cleared", rd_inv[0], 0);
        rd(4);
        chkv("R8 inv cleared r4", rd_inv[0], 0);
        step();
        chkv("R8 redirect one cycle", redirect_valid, 0);
    endtask

    task automatic t_exit_all();
        do_reset();
        miss_valid = 1; miss_pc = 'h20; miss_line = 3;
        step();
        req_valid = 1; req_base = 0; req_line = 9; #1;
        chkv("R9 grant 1", req_grant_b, 1);
        step();
        req_valid = 1; req_base = 0; req_line = 10; #1;
        chkv("R9 grant 2", req_grant_b, 1);
        step();
        resp_valid = 1; resp_line = 3;
        step();
        chkv("R8 policy miss exits", runahead, 0);
        chkv("R9 policy all waits", runahead_b, 1);
        chkv("R9 no redirect yet", redirect_valid_b, 0);
        resp_valid = 1; resp_line = 9;
        step();
        chkv("R9 still waiting", runahead_b, 1);
        resp_valid = 1; resp_line = 10;
        step();
        chkv("R9 exit after all", runahead_b, 0);
        chkv("R9 redirect", redirect_valid_b, 1);
        chkv("R9 redirect pc", redirect_pc_b, 'h20);
    endtask

    task automatic t_cap();
        do_reset();
        miss_valid = 1; miss_pc = 'h30; miss_line = 1;
        step();
        for (int i = 0; i < MAXFLY - 1; i++) begin
            req_valid = 1; req_base = 0; req_line = LINEW'(20 + i); #1;
            chkv("R5 under limit", req_grant, 1);
            step();
        end
        req_valid = 1; req_base = 0; req_line = 40; #1;
        chkv("R5 limit refused", req_grant, 0);
        step();
        resp_valid = 1; resp_line = 20;
        step();
        req_valid = 1; req_base = 0; req_line = 40; #1;
        chkv("R5 slot freed", req_grant, 1);
    endtask

    initial begin
        idle();
        rd_idx = '0;
        t_reset();
        t_normal();
        t_enter_exit();
        t_exit_all();
        t_cap();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #500000;
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule